// File: doc/BRIEF.md
# Single-Requester Bus Handover Controller

This block sits beside a bus master and hands the shared bus to one alternate master, such as a DMA engine, through a three-wire handshake. The alternate master raises a request. The controller answers with a grant only once the current master has finished any bus cycle it was running. The alternate master then asserts its acknowledge and holds it for as long as it owns the bus.

While the bus is handed over, the controller drops an enable that puts the current master's address, data, strobe and direction drivers into high impedance. It also produces a qualifier that tells the alternate master when it may assert its acknowledge. That happens only while the grant is active and the strobe, the transfer acknowledge and the foreign acknowledge are all idle. When the acknowledge is released, the controller passes through a one-clock release state and gives the bus back.

Every input is resynchronised through a chain of flip-flops before use, so the inputs may come from another clock domain. All signals are active high.

Top module: `bus_handover_ctrl`

## Requirements
- R1: While reset is asserted and right after it, grant_o is 0, own_drive_en_o is 1 and alt_may_take_o is 0.
- R2: Each input passes through SYNC_STAGES (default 2) flip-flops before the controller uses it. With the bus otherwise idle, a request raised before clock edge 1 produces grant_o at 1 after edge 4 and not before.
- R3: A request is accepted only while the synchronised acknowledge is 0. While the acknowledge is held by another master, the request does not lead to a grant.
- R4: grant_o rises only in the clock after the synchronised cycle-busy, strobe and transfer-acknowledge inputs were all 0 while a request was pending.
- R5: grant_o falls one clock after the acknowledge is sampled at 1. Dropping the request while the acknowledge is held has no effect on the outputs.
- R6: own_drive_en_o is 0 from the clock grant_o rises until the controller leaves the granted state, and 1 otherwise.
- R7: alt_may_take_o equals grant_o AND NOT strobe AND NOT transfer-acknowledge AND NOT acknowledge, all taken as synchronised values.
- R8: When the acknowledge falls after having been seen, the controller spends exactly one clock in a release state and then returns to idle. own_drive_en_o returns to 1 on entering the release state.
- R9: If the request is withdrawn before any acknowledge is seen, a pending or active grant is dropped within one clock through the release state, and the bus returns to the current master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Request from the alternate master |
| alt_ack_i | input | 1 | Ownership acknowledge from the alternate master |
| own_strobe_i | input | 1 | Current master's address strobe is active |
| xfer_ack_i | input | 1 | Transfer acknowledge line is active |
| cyc_busy_i | input | 1 | Current master has a bus cycle in progress |
| grant_o | output | 1 | Grant to the alternate master |
| own_drive_en_o | output | 1 | Enable for the current master's bus drivers (0 means high impedance) |
| alt_may_take_o | output | 1 | Alternate master may assert its acknowledge |

## Verification
The handover is exercised four ways. A clean request–grant–acknowledge–release sequence checks the basic order and the synchroniser latency. A request that arrives during a long busy cycle with the strobe and transfer acknowledge active separates waiting for bus idle from granting at once. A request made while a foreign acknowledge is held shows that the grant is held back. A request withdrawn before any acknowledge, and a request dropped while the acknowledge is held, separate an abandoned handover from a completed one. A behavioural model compares every output on every clock.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;

    typedef enum logic [1:0] {
        HO_IDLE    = 2'd0,
        HO_PENDING = 2'd1,
        HO_GRANTED = 2'd2,
        HO_RELEASE = 2'd3
    } ho_state_e;

    // synchronised input vector bit positions
    localparam int unsigned IN_REQ   = 0;
    localparam int unsigned IN_ACK   = 1;
    localparam int unsigned IN_STRB  = 2;
    localparam int unsigned IN_XACK  = 3;
    localparam int unsigned IN_BUSY  = 4;
    localparam int unsigned IN_COUNT = 5;

    typedef struct packed {
        ho_state_e state;
        logic      grant;
        logic      seen;
    } ho_regs_t;

endpackage

// File: rtl/bus_handover_sync.sv
module bus_handover_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [STAGES-1:0][WIDTH-1:0] chain_d;

    always_comb begin
        chain_d[0] = async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_comb begin
            chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_handover_fsm.sv
module bus_handover_fsm
    import bus_handover_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_req,
    input  logic      s_ack,
    input  logic      s_strb,
    input  logic      s_xack,
    input  logic      s_busy,
    output logic      grant,
    output logic      drive_en
);
    ho_regs_t regs_q, regs_d;
    logic     bus_idle;

    assign bus_idle = !s_busy && !s_strb && !s_xack;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            HO_IDLE: begin
                regs_d.grant = 1'b0;
                regs_d.seen  = 1'b0;
                if (s_req && !s_ack) regs_d.state = HO_PENDING;
            end
            HO_PENDING: begin
                if (!s_req) begin
                    regs_d.state = HO_IDLE;
                end else if (bus_idle) begin
                    regs_d.state = HO_GRANTED;
                    regs_d.grant = 1'b1;
                end
            end
            HO_GRANTED: begin
                regs_d.grant = regs_q.grant && !s_ack;
                regs_d.seen  = regs_q.seen || s_ack;
                if (regs_q.seen && !s_ack) begin
                    regs_d.state = HO_RELEASE;
                    regs_d.grant = 1'b0;
                end else if (!regs_q.seen && !s_ack && !s_req) begin
                    regs_d.state = HO_RELEASE;
                    regs_d.grant = 1'b0;
                end
            end
            HO_RELEASE: begin
                regs_d.state = HO_IDLE;
                regs_d.grant = 1'b0;
                regs_d.seen  = 1'b0;
            end
            default: regs_d = '{HO_IDLE, 1'b0, 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{HO_IDLE, 1'b0, 1'b0};
        else        regs_q <= regs_d;
    end

    assign grant    = regs_q.grant;
    assign drive_en = (regs_q.state != HO_GRANTED);

    // R4
    grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(!s_busy && !s_strb && !s_xack && s_req));

    // R5
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && s_ack) |=> !grant);

    // R3
    foreign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == HO_IDLE && s_ack) |=> (regs_q.state == HO_IDLE));

    // R8
    release_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == HO_RELEASE) |=> (regs_q.state == HO_IDLE));

    // R6
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !drive_en);
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
    import bus_handover_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_i,
    input  logic alt_ack_i,
    input  logic own_strobe_i,
    input  logic xfer_ack_i,
    input  logic cyc_busy_i,
    output logic grant_o,
    output logic own_drive_en_o,
    output logic alt_may_take_o
);
    logic [IN_COUNT-1:0] raw_in;
    logic [IN_COUNT-1:0] syn_in;

    always_comb begin
        raw_in          = '0;
        raw_in[IN_REQ]  = bus_req_i;
        raw_in[IN_ACK]  = alt_ack_i;
        raw_in[IN_STRB] = own_strobe_i;
        raw_in[IN_XACK] = xfer_ack_i;
        raw_in[IN_BUSY] = cyc_busy_i;
    end

    bus_handover_sync #(
        .WIDTH  (IN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    bus_handover_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_req    (syn_in[IN_REQ]),
        .s_ack    (syn_in[IN_ACK]),
        .s_strb   (syn_in[IN_STRB]),
        .s_xack   (syn_in[IN_XACK]),
        .s_busy   (syn_in[IN_BUSY]),
        .grant    (grant_o),
        .drive_en (own_drive_en_o)
    );

    assign alt_may_take_o = grant_o && !syn_in[IN_STRB] && !syn_in[IN_XACK]
                            && !syn_in[IN_ACK];

    // R7
    take_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_may_take_o |-> (grant_o && !own_drive_en_o));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (!grant_o && own_drive_en_o && !alt_may_take_o));
endmodule

// File: tb/bus_handover_ctrl_bench.sv
module bus_handover_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STAGES     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 0, ack = 0, strb = 0, xack = 0, busy = 0;
    logic grant, drv, take;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_handover_ctrl #(.SYNC_STAGES(STAGES)) u_bus_handover_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req), .alt_ack_i(ack),
        .own_strobe_i(strb), .xfer_ack_i(xack), .cyc_busy_i(busy),
        .grant_o(grant), .own_drive_en_o(drv), .alt_may_take_o(take));

    // behavioural reference: input history queues plus a phase number
    // phase 0 idle, 1 waiting, 2 handed over, 3 returning
    bit hist[$][5];
    int m_phase = 0;
    bit m_grant = 0, m_seen = 0;
    bit d_req, d_ack, d_strb, d_xack, d_busy;

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            hist.delete();
            m_phase = 0; m_grant = 0; m_seen = 0;
        end else begin
            // values seen by the controller this edge: inputs STAGES edges old
            if (hist.size() >= STAGES) begin
                d_req = hist[0][0]; d_ack = hist[0][1]; d_strb = hist[0][2];
                d_xack = hist[0][3]; d_busy = hist[0][4];
            end else begin
                d_req = 0; d_ack = 0; d_strb = 0; d_xack = 0; d_busy = 0;
            end
            if (m_phase == 0) begin
                m_grant = 0; m_seen = 0;
                if (d_req && !d_ack) m_phase = 1;
            end else if (m_phase == 1) begin
                if (!d_req) m_phase = 0;
                else if (!d_busy && !d_strb && !d_xack) begin
                    m_phase = 2; m_grant = 1;
                end
            end else if (m_phase == 2) begin
                if (m_seen && !d_ack) begin
                    m_phase = 3; m_grant = 0;
                end else if (!m_seen && !d_ack && !d_req) begin
                    m_phase = 3; m_grant = 0;
                end else begin
                    if (d_ack) m_grant = 0;
                    if (d_ack) m_seen = 1;
                end
            end else begin
                m_phase = 0; m_grant = 0; m_seen = 0;
            end
            if (hist.size() >= STAGES) void'(hist.pop_front());
            hist.push_back('{req, ack, strb, xack, busy});
        end
    end

    function automatic bit model_take();
        bit s_strb, s_xack, s_ack;
        if (hist.size() < STAGES) return 0;
        s_ack = hist[0][1]; s_strb = hist[0][2]; s_xack = hist[0][3];
        return m_grant && !s_strb && !s_xack && !s_ack;
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R4/R5/R9 grant", grant, m_grant);
            check("R6/R8 drive", drv, m_phase != 2);
            check("R7 take", take, model_take());
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        // R1
        check("R1 grant", grant, 1'b0);
        check("R1 drive", drv, 1'b1);
        check("R1 take", take, 1'b0);
        rst_n = 1;
        step(2);

        // R2: clean handover latency
        req = 1;
        step(3);
        check("R2 grant not yet", grant, 1'b0);
        step(1);
        check("R2 grant at edge 4", grant, 1'b1);
        check("R7 take allowed", take, 1'b1);
        check("R6 drivers off", drv, 1'b0);
        ack = 1;
        step(3);
        check("R5 grant withdrawn", grant, 1'b0);
        req = 0;                      // R5: request drop while acknowledge held
        step(4);
        check("R5 still owned", drv, 1'b0);
        ack = 0;
        step(3);
        check("R8 release drives back", drv, 1'b1);
        step(1);
        check("R8 idle", grant, 1'b0);
        step(3);

        // R4: busy cycle with strobe and transfer acknowledge
        busy = 1; strb = 1; xack = 1;
        req = 1;
        step(8);
        check("R4 held while busy", grant, 1'b0);
        busy = 0; strb = 0;
        step(6);
        check("R4 held by xfer ack", grant, 1'b0);
        xack = 0;
        step(4);
        check("R4 granted when idle", grant, 1'b1);
        // R9: withdraw before acknowledge
        req = 0;
        step(4);
        check("R9 grant dropped", grant, 1'b0);
        check("R9 drivers back", drv, 1'b1);
        step(3);

        // R3: foreign acknowledge blocks request
        ack = 1;
        step(3);
        req = 1;
        step(8);
        check("R3 no grant under foreign ack", grant, 1'b0);
        check("R3 drivers kept", drv, 1'b1);
        ack = 0;
        step(5);
        check("R3 grant after ack gone", grant, 1'b1);
        strb = 1;
        step(3);
        check("R7 take blocked by strobe", take, 1'b0);
        strb = 0; req = 0;
        step(8);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule